// File: doc/BRIEF.md
# Plasma Panel Subfield Drive Sequencer

This block produces the digital timing for one subfield of an AC plasma panel that keeps addressing apart from display. A start strobe launches the subfield. First comes a reset phase: a rising ramp on the Y electrode, then a falling ramp on Y while X is held at its bias level. An address phase follows. It selects scan lines one at a time through a serial one-hot token, so that external 64-output scan drivers can be cascaded, and it strobes address data for each selected line. The subfield ends with a sustain phase, a train of pulses that alternates between Y and X.

The sustain train always opens on Y and closes on X. A programmable number of leading pulses use a wider width to settle the first discharges. The final X pulse uses a narrow erase width. The four high-voltage switch enables (Y sustain, Y ground, X sustain, X ground) never overlap. Every change from one enable to another passes through at least one all-off cycle. The configuration inputs are captured only when a subfield starts.

The controller has eleven states. IDLE goes to RAMP_UP on start. RAMP_UP goes to RAMP_DN when its timer ends, and RAMP_DN goes to SCAN_SHIFT when its timer ends. Each line then runs SCAN_SHIFT, then SCAN_LATCH, then SCAN_HOLD. SCAN_HOLD returns to SCAN_SHIFT, or goes to SUS_LEAD after the last line. Each sustain pulse runs SUS_LEAD, then SUS_ON, then SUS_TRAIL, then SUS_CLAMP. SUS_CLAMP returns to SUS_LEAD, or goes to FINISH after the last pulse. FINISH goes to IDLE.

Top module: `pdp_subfield_seq`

## Requirements
- R1: After reset, and whenever reset is asserted, every output is low and `busy` is low.
- R2: Two phases run in order after an accepted start. First `y_ramp_up` is high for the ramp time. Then `y_ramp_dn` is high for the ramp time, with `x_ve` high in exactly those cycles. The first scan clock follows in the very next cycle.
- R3: The address phase handles each line in turn. For each line, `scan_clk` is high for one cycle and `scan_latch` is high in the next cycle. `addr_strobe` is then high for the address time. `scan_data` is high only together with the first line's `scan_clk`.
- R4: The sustain phase has 2×pairs pulses. They alternate between electrodes, the first on Y (`y_sus`) and the last on X (`x_sus`).
- R5: Pulse k (counted from 0) lasts the erase width if it is the last pulse. Otherwise it lasts the wide width if k is less than the wide count, and the normal width in every other case.
- R6: At most one of `y_sus`, `y_gnd`, `x_sus`, `x_gnd` is high in any cycle, and no cycle switches directly from one enable to another. Each pulse is built from four parts in order: dead time with all enables off, the sustain enable for the pulse width, dead time with all enables off, and the same electrode's ground enable for the dead time.
- R7: `done` is high for exactly one cycle, in the last `busy` cycle. That cycle comes straight after the final ground clamp. The subfield lasts 2·ramp + lines·(2+addr) + Σ(3·dead + width_k) + 1 cycles.
- R8: A start that arrives while `busy` is high has no effect on the running subfield or on its length.
- R9: A change to any configuration input after the start has no effect until the next accepted start.
- R10: A configuration value of zero (lines, pairs, any width, ramp time, address time or dead time) acts as one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Subfield start strobe, accepted only when idle |
| cfg_lines | input | LINE_W | Number of scan lines |
| cfg_pairs | input | PAIR_W | Number of Y/X sustain pulse pairs |
| cfg_wide | input | PAIR_W+1 | Number of leading wide pulses |
| cfg_ramp | input | TW | Cycles of each reset ramp |
| cfg_addr | input | TW | Cycles of address data per line |
| cfg_w_norm | input | TW | Normal sustain pulse width |
| cfg_w_wide | input | TW | Wide sustain pulse width |
| cfg_w_erase | input | TW | Width of the final erase pulse on X |
| cfg_dead | input | TW | Dead time between switch enables |
| y_ramp_up | output | 1 | Y rising ramp enable |
| y_ramp_dn | output | 1 | Y falling ramp enable |
| x_ve | output | 1 | X bias-level hold enable |
| y_sus | output | 1 | Y sustain switch enable |
| y_gnd | output | 1 | Y ground switch enable |
| x_sus | output | 1 | X sustain switch enable |
| x_gnd | output | 1 | X ground switch enable |
| scan_clk | output | 1 | Scan driver shift clock |
| scan_data | output | 1 | Scan token serial data |
| scan_latch | output | 1 | Scan driver latch strobe |
| addr_strobe | output | 1 | Address data hold window for the selected line |
| busy | output | 1 | Subfield in progress |
| done | output | 1 | One-cycle end-of-subfield pulse |

## Verification
The bench replays a full subfield for each configuration and checks five things:
- the total length of the subfield;
- the cycle of `done`;
- the position of each phase;
- the order and width of every sustain pulse;
- the direct transitions between switch enables.

Any fault in the state, timer or counters moves one of these quantities, so it shows at the ports within the same subfield. A wrong line counter changes the count of scan clocks and every later cycle index. A wrong pulse index swaps electrodes or widths, and that shows in the first wrong pulse. A timer fault stretches or shrinks a phase, and that shows as soon as the phase ends. A wrongly taken start, or a configuration captured mid-run, changes the subfield length before `done`.

// File: rtl/pdp_seq_pkg.sv
package pdp_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RAMP_UP,
        ST_RAMP_DN,
        ST_SCAN_SHIFT,
        ST_SCAN_LATCH,
        ST_SCAN_HOLD,
        ST_SUS_LEAD,
        ST_SUS_ON,
        ST_SUS_TRAIL,
        ST_SUS_CLAMP,
        ST_FINISH
    } seq_state_t;

    typedef enum logic [1:0] {
        PK_NORMAL,
        PK_WIDE,
        PK_ERASE
    } pulse_kind_t;

endpackage

// File: rtl/pdp_width_timer.sv
module pdp_width_timer #(
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          last
);
    localparam logic [TW-1:0] ONE = TW'(1);

    logic [TW-1:0] rem;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem <= ONE;
        end else if (load) begin
            rem <= (load_val == '0) ? ONE : load_val;
        end else if (rem > ONE) begin
            rem <= rem - ONE;
        end
    end

    assign last = (rem <= ONE);

endmodule

// File: rtl/pdp_step_counter.sv
module pdp_step_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (step) begin
            count <= count + W'(1);
        end
    end
endmodule

// File: rtl/pdp_pulse_sel.sv
module pdp_pulse_sel
    import pdp_seq_pkg::*;
#(
    parameter int PAIR_W = 8,
    parameter int TW     = 12
) (
    input  logic [PAIR_W:0]   idx,
    input  logic [PAIR_W-1:0] pairs,
    input  logic [PAIR_W:0]   wide_cnt,
    input  logic [TW-1:0]     w_norm,
    input  logic [TW-1:0]     w_wide,
    input  logic [TW-1:0]     w_erase,
    output logic              on_x,
    output logic              is_last,
    output pulse_kind_t       kind,
    output logic [TW-1:0]     width
);
    localparam int IW = PAIR_W + 1;

    logic [IW-1:0] last_idx;

    always_comb begin
        last_idx = {pairs, 1'b0} - IW'(1);
        on_x     = idx[0];
        is_last  = (idx == last_idx);
        if (is_last) begin
            kind = PK_ERASE;
        end else if (idx < wide_cnt) begin
            kind = PK_WIDE;
        end else begin
            kind = PK_NORMAL;
        end
        unique case (kind)
            PK_ERASE: width = w_erase;
            PK_WIDE:  width = w_wide;
            default:  width = w_norm;
        endcase
    end
endmodule

// File: rtl/pdp_subfield_seq.sv
module pdp_subfield_seq
    import pdp_seq_pkg::*;
#(
    parameter int LINE_W = 10,
    parameter int PAIR_W = 8,
    parameter int TW     = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LINE_W-1:0] cfg_lines,
    input  logic [PAIR_W-1:0] cfg_pairs,
    input  logic [PAIR_W:0]   cfg_wide,
    input  logic [TW-1:0]     cfg_ramp,
    input  logic [TW-1:0]     cfg_addr,
    input  logic [TW-1:0]     cfg_w_norm,
    input  logic [TW-1:0]     cfg_w_wide,
    input  logic [TW-1:0]     cfg_w_erase,
    input  logic [TW-1:0]     cfg_dead,
    output logic              y_ramp_up,
    output logic              y_ramp_dn,
    output logic              x_ve,
    output logic              y_sus,
    output logic              y_gnd,
    output logic              x_sus,
    output logic              x_gnd,
    output logic              scan_clk,
    output logic              scan_data,
    output logic              scan_latch,
    output logic              addr_strobe,
    output logic              busy,
    output logic              done
);
    localparam int            IW    = PAIR_W + 1;
    localparam logic [TW-1:0] T_ONE = TW'(1);

    seq_state_t state, state_nx;

    logic [LINE_W-1:0] lines_q;
    logic [PAIR_W-1:0] pairs_q;
    logic [PAIR_W:0]   wide_q;
    logic [TW-1:0]     ramp_q, addr_q, wn_q, ww_q, we_q, dead_q;

    logic              accept;
    logic              t_last;
    logic              t_load;
    logic [TW-1:0]     t_val;
    logic [LINE_W-1:0] line_cnt;
    logic [IW-1:0]     pulse_idx;
    logic              last_line;
    logic              p_on_x, p_last;
    pulse_kind_t       p_kind;
    logic [TW-1:0]     p_width;

    assign accept = (state == ST_IDLE) && start;

    // configuration capture, zero counts folded to one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lines_q <= LINE_W'(1);
            pairs_q <= PAIR_W'(1);
            wide_q  <= '0;
            ramp_q  <= T_ONE;
            addr_q  <= T_ONE;
            wn_q    <= T_ONE;
            ww_q    <= T_ONE;
            we_q    <= T_ONE;
            dead_q  <= T_ONE;
        end else if (accept) begin
            lines_q <= (cfg_lines == '0) ? LINE_W'(1) : cfg_lines;
            pairs_q <= (cfg_pairs == '0) ? PAIR_W'(1) : cfg_pairs;
            wide_q  <= cfg_wide;
            ramp_q  <= cfg_ramp;
            addr_q  <= cfg_addr;
            wn_q    <= cfg_w_norm;
            ww_q    <= cfg_w_wide;
            we_q    <= cfg_w_erase;
            dead_q  <= cfg_dead;
        end
    end

    pdp_step_counter #(.W(LINE_W)) u_line_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .step  ((state == ST_SCAN_HOLD) && t_last),
        .count (line_cnt)
    );

    pdp_step_counter #(.W(IW)) u_pulse_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .step  ((state == ST_SUS_CLAMP) && t_last),
        .count (pulse_idx)
    );

    pdp_pulse_sel #(.PAIR_W(PAIR_W), .TW(TW)) u_pulse_sel (
        .idx      (pulse_idx),
        .pairs    (pairs_q),
        .wide_cnt (wide_q),
        .w_norm   (wn_q),
        .w_wide   (ww_q),
        .w_erase  (we_q),
        .on_x     (p_on_x),
        .is_last  (p_last),
        .kind     (p_kind),
        .width    (p_width)
    );

    assign last_line = (line_cnt == (lines_q - LINE_W'(1)));

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:       if (start)  state_nx = ST_RAMP_UP;
            ST_RAMP_UP:    if (t_last) state_nx = ST_RAMP_DN;
            ST_RAMP_DN:    if (t_last) state_nx = ST_SCAN_SHIFT;
            ST_SCAN_SHIFT: state_nx = ST_SCAN_LATCH;
            ST_SCAN_LATCH: state_nx = ST_SCAN_HOLD;
            ST_SCAN_HOLD:  if (t_last) state_nx = last_line ? ST_SUS_LEAD : ST_SCAN_SHIFT;
            ST_SUS_LEAD:   if (t_last) state_nx = ST_SUS_ON;
            ST_SUS_ON:     if (t_last) state_nx = ST_SUS_TRAIL;
            ST_SUS_TRAIL:  if (t_last) state_nx = ST_SUS_CLAMP;
            ST_SUS_CLAMP:  if (t_last) state_nx = p_last ? ST_FINISH : ST_SUS_LEAD;
            ST_FINISH:     state_nx = ST_IDLE;
            default:       state_nx = ST_IDLE;
        endcase
    end

    // timer reload on every state change
    always_comb begin
        t_load = (state_nx != state);
        unique case (state_nx)
            ST_RAMP_UP:   t_val = (state == ST_IDLE) ? cfg_ramp : ramp_q;
            ST_RAMP_DN:   t_val = ramp_q;
            ST_SCAN_HOLD: t_val = addr_q;
            ST_SUS_LEAD,
            ST_SUS_TRAIL,
            ST_SUS_CLAMP: t_val = dead_q;
            ST_SUS_ON:    t_val = p_width;
            default:      t_val = T_ONE;
        endcase
    end

    pdp_width_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .last     (t_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // outputs
    always_comb begin
        y_ramp_up   = 1'b0;
        y_ramp_dn   = 1'b0;
        x_ve        = 1'b0;
        y_sus       = 1'b0;
        y_gnd       = 1'b0;
        x_sus       = 1'b0;
        x_gnd       = 1'b0;
        scan_clk    = 1'b0;
        scan_data   = 1'b0;
        scan_latch  = 1'b0;
        addr_strobe = 1'b0;
        done        = 1'b0;
        busy        = (state != ST_IDLE);
        unique case (state)
            ST_RAMP_UP:    y_ramp_up = 1'b1;
            ST_RAMP_DN: begin
                y_ramp_dn = 1'b1;
                x_ve      = 1'b1;
            end
            ST_SCAN_SHIFT: begin
                scan_clk  = 1'b1;
                scan_data = (line_cnt == '0);
            end
            ST_SCAN_LATCH: scan_latch  = 1'b1;
            ST_SCAN_HOLD:  addr_strobe = 1'b1;
            ST_SUS_ON: begin
                y_sus = !p_on_x;
                x_sus = p_on_x;
            end
            ST_SUS_CLAMP: begin
                y_gnd = !p_on_x;
                x_gnd = p_on_x;
            end
            ST_FINISH:     done = 1'b1;
            default: ;
        endcase
    end

    // ---------------- assertions ----------------
    logic [3:0] sw_vec;
    assign sw_vec = {y_sus, y_gnd, x_sus, x_gnd};

    p_onehot_sw_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sw_vec));

    p_dead_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_vec != 4'b0) && ($past(sw_vec) != 4'b0) |-> (sw_vec == $past(sw_vec)));

    p_ramp_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(y_ramp_dn) |-> $past(y_ramp_up));

    p_latch_after_clk_r3: assert property (@(posedge clk) disable iff (!rst_n)
        scan_clk |=> scan_latch);

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start && busy && !done |=> busy);

    p_sus_first_y_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(addr_strobe) && !scan_clk |-> !x_sus && !x_gnd);

endmodule

// File: tb/pdp_subfield_seq_test.sv
`timescale 1ns/1ps
module pdp_subfield_seq_test;
    localparam int LINE_W = 10;
    localparam int PAIR_W = 8;
    localparam int TW     = 12;

    // R, L, A, P, Wc, Wn, Ww, We, D
    localparam int NCASE = 4;
    localparam int CFG [NCASE][9] = '{
        '{4, 3, 2, 3, 2, 3, 6, 1, 1},
        '{2, 1, 1, 1, 0, 2, 5, 1, 2},
        '{1, 5, 3, 4, 6, 2, 4, 1, 1},
        '{3, 2, 1, 2, 9, 2, 4, 2, 3}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [LINE_W-1:0] cfg_lines = '0;
    logic [PAIR_W-1:0] cfg_pairs = '0;
    logic [PAIR_W:0]   cfg_wide = '0;
    logic [TW-1:0] cfg_ramp = '0, cfg_addr = '0, cfg_w_norm = '0;
    logic [TW-1:0] cfg_w_wide = '0, cfg_w_erase = '0, cfg_dead = '0;
    logic y_ramp_up, y_ramp_dn, x_ve, y_sus, y_gnd, x_sus, x_gnd;
    logic scan_clk, scan_data, scan_latch, addr_strobe, busy, done;

    int total = 0;
    int bad = 0;
    int pel [64];
    int pwd [64];

    always #2.5 clk = ~clk;

    pdp_subfield_seq #(.LINE_W(LINE_W), .PAIR_W(PAIR_W), .TW(TW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_lines(cfg_lines), .cfg_pairs(cfg_pairs), .cfg_wide(cfg_wide),
        .cfg_ramp(cfg_ramp), .cfg_addr(cfg_addr), .cfg_w_norm(cfg_w_norm),
        .cfg_w_wide(cfg_w_wide), .cfg_w_erase(cfg_w_erase), .cfg_dead(cfg_dead),
        .y_ramp_up(y_ramp_up), .y_ramp_dn(y_ramp_dn), .x_ve(x_ve),
        .y_sus(y_sus), .y_gnd(y_gnd), .x_sus(x_sus), .x_gnd(x_gnd),
        .scan_clk(scan_clk), .scan_data(scan_data), .scan_latch(scan_latch),
        .addr_strobe(addr_strobe), .busy(busy), .done(done)
    );

    function automatic int f1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic all_low(input string req);
        logic [12:0] v;
        v = {y_ramp_up, y_ramp_dn, x_ve, y_sus, y_gnd, x_sus, x_gnd,
             scan_clk, scan_data, scan_latch, addr_strobe, busy, done};
        chk(v == '0, req, int'(v), 0);
    endtask

    task automatic set_cfg(input int r, l, a, p, wc, wn, ww, we, d);
        cfg_ramp    = TW'(r);
        cfg_lines   = LINE_W'(l);
        cfg_addr    = TW'(a);
        cfg_pairs   = PAIR_W'(p);
        cfg_wide    = (PAIR_W+1)'(wc);
        cfg_w_norm  = TW'(wn);
        cfg_w_wide  = TW'(ww);
        cfg_w_erase = TW'(we);
        cfg_dead    = TW'(d);
    endtask

    task automatic run_case(input int r, l, a, p, wc, wn, ww, we, d, input int inj_at);
        int fr, fl, fa, fp, fd, npul, expt, n;
        int up_c, dn_c, ve_bad, first_clk, clk_c, dat_bad, dat_c, lat_c, lat_bad, stb_c;
        int yg_c, xg_c, viol, done_c, done_idx, yrun, xrun, alt_bad, wid_bad;
        logic [3:0] sw, psw;
        logic pclk, py, px;
        fr = f1(r); fl = f1(l); fa = f1(a); fp = f1(p); fd = f1(d);
        expt = 2*fr + fl*(2+fa) + 1;
        for (int k = 0; k < 2*fp; k++) begin
            int w;
            w = (k == 2*fp-1) ? we : ((k < wc) ? ww : wn);
            expt += 3*fd + f1(w);
        end
        up_c = 0; dn_c = 0; ve_bad = 0; first_clk = -1; clk_c = 0; dat_bad = 0; dat_c = 0;
        lat_c = 0; lat_bad = 0; stb_c = 0; yg_c = 0; xg_c = 0; viol = 0; done_c = 0;
        done_idx = -1; yrun = 0; xrun = 0; npul = 0; n = 0;
        psw = '0; pclk = 1'b0; py = 1'b0; px = 1'b0;
        @(negedge clk);
        set_cfg(r, l, a, p, wc, wn, ww, we, d);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy && n < 20000) begin
            sw = {y_sus, y_gnd, x_sus, x_gnd};
            if (y_ramp_up) up_c++;
            if (y_ramp_dn) dn_c++;
            if (x_ve != y_ramp_dn) ve_bad++;
            if (scan_clk) begin
                if (first_clk < 0) first_clk = n;
                if (scan_data && clk_c != 0) dat_bad++;
                if (!scan_data && clk_c == 0) dat_bad++;
                clk_c++;
            end
            if (scan_data) dat_c++;
            if (scan_data && !scan_clk) dat_bad++;
            if (scan_latch) begin
                lat_c++;
                if (!pclk) lat_bad++;
            end
            if (addr_strobe) stb_c++;
            if (y_gnd) yg_c++;
            if (x_gnd) xg_c++;
            if (sw != 4'b0 && psw != 4'b0 && sw != psw) viol++;
            if (sw != 4'b0 && sw != 4'b1000 && sw != 4'b0100 && sw != 4'b0010 && sw != 4'b0001) viol++;
            if (y_sus) yrun++;
            if (x_sus) xrun++;
            if (py && !y_sus) begin
                if (npul < 64) begin pel[npul] = 0; pwd[npul] = yrun; end
                npul++; yrun = 0;
            end
            if (px && !x_sus) begin
                if (npul < 64) begin pel[npul] = 1; pwd[npul] = xrun; end
                npul++; xrun = 0;
            end
            if (done) begin done_c++; done_idx = n; end
            psw = sw; pclk = scan_clk; py = y_sus; px = x_sus;
            n++;
            if (inj_at >= 0 && n == inj_at) begin
                start = 1'b1;
                set_cfg(r+3, l+2, a+4, p+1, wc+1, wn+5, ww+2, we+3, d+1);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(n == expt, "R7 subfield length", n, expt);
        chk(done_c == 1 && done_idx == n-1, "R7 done single in last busy cycle", done_idx, n-1);
        chk(up_c == fr, "R2 ramp up cycles", up_c, fr);
        chk(dn_c == fr && ve_bad == 0, "R2 ramp down with x_ve", dn_c + 1000*ve_bad, fr);
        chk(first_clk == 2*fr, "R2 first scan clock cycle", first_clk, 2*fr);
        chk(clk_c == fl, "R3 scan clocks", clk_c, fl);
        chk(dat_c == 1 && dat_bad == 0, "R3 scan token on first line only", dat_c + 1000*dat_bad, 1);
        chk(lat_c == fl && lat_bad == 0, "R3 latch after each clock", lat_c + 1000*lat_bad, fl);
        chk(stb_c == fl*fa, "R3 address strobe cycles", stb_c, fl*fa);
        chk(npul == 2*fp, "R4 sustain pulse count", npul, 2*fp);
        alt_bad = 0; wid_bad = 0;
        for (int k = 0; k < npul && k < 64; k++) begin
            int w;
            if (pel[k] != (k % 2)) alt_bad++;
            w = (k == 2*fp-1) ? we : ((k < wc) ? ww : wn);
            if (pwd[k] != f1(w)) begin
                wid_bad++;
                $display("FAIL R5 pulse %0d width actual=%0d expected=%0d", k, pwd[k], f1(w));
            end
        end
        chk(alt_bad == 0 && npul > 0 && pel[0] == 0, "R4 alternation starts Y ends X", alt_bad, 0);
        chk(wid_bad == 0, "R5 pulse widths", wid_bad, 0);
        chk(viol == 0, "R6 exclusive enables with dead gap", viol, 0);
        chk(yg_c == fp*fd && xg_c == fp*fd, "R6 ground clamp cycles", yg_c + xg_c, 2*fp*fd);
        all_low("R1 idle after subfield");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        all_low("R1 outputs during reset");
        rst_n = 1'b1;
        @(negedge clk);
        all_low("R1 outputs after reset");

        for (int c = 0; c < NCASE; c++) begin
            run_case(CFG[c][0], CFG[c][1], CFG[c][2], CFG[c][3], CFG[c][4],
                     CFG[c][5], CFG[c][6], CFG[c][7], CFG[c][8], -1);
        end

        // R8 / R9: start pulse and new configuration mid-subfield
        run_case(4, 3, 2, 3, 2, 3, 6, 1, 1, 20);
        // R8 / R9: the same during sustain
        run_case(2, 2, 1, 2, 1, 3, 5, 2, 1, 30);

        // R10: all zero configuration acts as one
        run_case(0, 0, 0, 0, 0, 0, 0, 0, 0, -1);

        // R1: reset asserted mid-subfield
        @(negedge clk);
        set_cfg(5, 4, 3, 2, 1, 2, 3, 1, 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (8) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        all_low("R1 outputs after mid-run reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        all_low("R1 stays idle after reset release");

        // restart works after reset
        run_case(1, 2, 1, 1, 1, 2, 3, 1, 1, -1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule